// File: doc/BRIEF.md
# Seven-to-eight bit transmit gearbox for a four-lane video link

This block sits in front of a serializer that runs an 8:1 double-data-rate ratio. The serializer cannot take 7-bit words, but the video link sends seven bits per lane per pixel clock. On each pixel-clock edge the block takes one 7-bit slice per lane and writes it into a circular bit buffer. On each serializer-parallel clock edge it reads one 8-bit word per lane from the same buffer. Because the serializer-parallel clock runs at exactly 7/8 of the pixel clock, the bit rates on the two sides are equal.

Each lane has its own ring of two 56-bit periods (112 bits). The write side puts slices at consecutive 7-bit offsets and wraps after 16 slices. The read side takes words at consecutive 8-bit offsets and wraps after 14 words. While the reset input is high, the serializer clock generator is treated as unlocked. On release, the write pointer starts at bit 0 and the read pointer starts half a ring away. The two sides therefore stay 56 bits apart and never touch the same bits. For 1080p60 the pixel clock is 148.5 MHz, which gives a line rate of 1.0395 Gbps per lane.

Top module: `vgb_tx_top`

## Requirements
- R1: On every pixel-clock edge with reset low, each of the four lanes stores its 7-bit input slice at the next consecutive 7-bit offset of its ring. Lane l input is `pix_data[7*l +: 7]`.
- R2: On every serializer-clock edge with reset low, each lane presents one registered 8-bit word on `ser_data[8*l +: 8]`.
- R3: Within an output word, bit 0 carries the earliest stream bit and bit 7 the latest. Within an input slice, bit 0 is the earliest of its seven bits.
- R4: From the eighth word after reset release onward, the concatenated output bits of a lane equal that lane's input bits in order, with no gap and no duplicate.
- R5: While reset is high, every serializer-clock edge drives `ser_data` to all zeros.
- R6: After reset release, writing starts at ring bit 0 and reading starts at ring bit 56. The first seven output words are priming words whose content is unspecified. Output word 7 carries input bits 0 to 7.
- R7: Asserting reset in mid-stream and releasing it again restarts the alignment of R6. No bits written before that reset appear after the seven priming words.
- R8: Lanes are independent. Distinct data on each lane comes out on the same lane unchanged.
- R9: The write offset wraps after 16 slices and the read offset after 14 words, and the stream stays continuous across both wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock, write side |
| ser_clk | input | 1 | Serializer-parallel clock, 7/8 of pix_clk, frequency-locked |
| rst | input | 1 | Active-high synchronous reset, sampled in both domains; high while clocks are unlocked |
| pix_data | input | 28 | Four 7-bit lane slices, lane l at bits [7l+6:7l] |
| ser_data | output | 32 | Four 8-bit lane words, lane l at bits [8l+7:8l] |

## Verification
The bench builds the block with its defaults: four lanes, a 7-bit input, an 8-bit output and two 56-bit periods. With these values a run of a few hundred serializer cycles passes through many wraps of both pointers. The bench drives counter, alternating and pseudo-random patterns that differ on every lane. It also re-asserts reset in mid-stream, so that the seven priming words and the restart alignment are exercised more than once.

// File: rtl/vgb_pkg.sv
package vgb_pkg;
  localparam int LANES_DEF   = 4;
  localparam int IN_W_DEF    = 7;
  localparam int OUT_W_DEF   = 8;
  localparam int PERIODS_DEF = 2;
endpackage

// File: rtl/vgb_wrap_ctr.sv
module vgb_wrap_ctr #(
  parameter int COUNT = 16,
  parameter int START = 0,
  localparam int CW   = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= CW'(START);
    else if (int'(cnt) == COUNT-1) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assert_ctr_range_R9: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < COUNT);

  assert_ctr_start_R6: assert property (@(posedge clk)
    rst |=> int'(cnt) == START);

  assert_ctr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) != COUNT-1) |=> (int'(cnt) == int'($past(cnt)) + 1));

  assert_ctr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) == COUNT-1) |=> (cnt == '0));
endmodule

// File: rtl/vgb_lane_ring.sv
module vgb_lane_ring #(
  parameter int IN_W     = 7,
  parameter int OUT_W    = 8,
  parameter int BUF_BITS = 112,
  localparam int WSLOTS  = BUF_BITS / IN_W,
  localparam int RSLOTS  = BUF_BITS / OUT_W,
  localparam int WPW     = $clog2(WSLOTS),
  localparam int RPW     = $clog2(RSLOTS)
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic [WPW-1:0]   wr_slot,
  input  logic [IN_W-1:0]  wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic [RPW-1:0]   rd_slot,
  output logic [OUT_W-1:0] rd_data
);
  // Circular bit store; data bits carry no reset.
  logic [BUF_BITS-1:0] ring;

  always_ff @(posedge wr_clk) begin
    if (!wr_rst) ring[int'(wr_slot)*IN_W +: IN_W] <= wr_data;
  end

  // Read side: bits are stable for many cycles around the read point.
  always_ff @(posedge rd_clk) begin
    if (rd_rst) rd_data <= '0;
    else        rd_data <= ring[int'(rd_slot)*OUT_W +: OUT_W];
  end

  assert_out_clear_R5: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_data == '0));

  assert_ring_hold_R1: assert property (@(posedge wr_clk)
    wr_rst |=> $stable(ring));
endmodule

// File: rtl/vgb_tx_top.sv
module vgb_tx_top
  import vgb_pkg::*;
#(
  parameter int LANES   = LANES_DEF,
  parameter int IN_W    = IN_W_DEF,
  parameter int OUT_W   = OUT_W_DEF,
  parameter int PERIODS = PERIODS_DEF,
  localparam int BUF_BITS = PERIODS * IN_W * OUT_W,
  localparam int WSLOTS   = BUF_BITS / IN_W,
  localparam int RSLOTS   = BUF_BITS / OUT_W,
  localparam int RSTART   = RSLOTS / 2,
  localparam int WPW      = $clog2(WSLOTS),
  localparam int RPW      = $clog2(RSLOTS)
) (
  input  logic                   pix_clk,
  input  logic                   ser_clk,
  input  logic                   rst,
  input  logic [LANES*IN_W-1:0]  pix_data,
  output logic [LANES*OUT_W-1:0] ser_data
);
  logic [WPW-1:0] wr_slot;
  logic [RPW-1:0] rd_slot;

  // Write pointer: starts at ring bit 0.
  vgb_wrap_ctr #(.COUNT(WSLOTS), .START(0)) u_wr_ptr (
    .clk(pix_clk), .rst(rst), .cnt(wr_slot)
  );

  // Read pointer: starts half a ring away from the writer.
  vgb_wrap_ctr #(.COUNT(RSLOTS), .START(RSTART)) u_rd_ptr (
    .clk(ser_clk), .rst(rst), .cnt(rd_slot)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vgb_lane_ring #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_BITS(BUF_BITS)) u_ring (
      .wr_clk (pix_clk),
      .wr_rst (rst),
      .wr_slot(wr_slot),
      .wr_data(pix_data[l*IN_W +: IN_W]),
      .rd_clk (ser_clk),
      .rd_rst (rst),
      .rd_slot(rd_slot),
      .rd_data(ser_data[l*OUT_W +: OUT_W])
    );
  end
endmodule

// File: tb/vgb_tx_top_tb_top.sv
`timescale 1ns/1ps
module vgb_tx_top_tb_top;
  localparam int LANES = 4;
  localparam int IW = 7;
  localparam int OW = 8;
  localparam int PRIME = 7;

  logic pix_clk = 1'b0, ser_clk = 1'b0, rst = 1'b1;
  logic [LANES*IW-1:0] pix_data = '0;
  logic [LANES*OW-1:0] ser_data;

  int checks = 0, errors = 0;
  int mode = 0;
  bit lane_q [LANES][$];
  bit last_rst = 1'b1;
  int word_idx = 0;
  bit done = 1'b0;

  vgb_tx_top dut_i (.pix_clk(pix_clk), .ser_clk(ser_clk), .rst(rst),
                    .pix_data(pix_data), .ser_data(ser_data));

  always #5.0   ser_clk = ~ser_clk;   // 100 MHz
  always #4.375 pix_clk = ~pix_clk;   // 8/7 of ser_clk

  // Stimulus: distinct per-lane patterns (R8), three pattern modes.
  initial begin
    int n = 0;
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(negedge pix_clk);
      for (int l = 0; l < LANES; l++) begin
        case (mode)
          0: pix_data[l*IW +: IW] <= IW'(n + 19*l);
          1: pix_data[l*IW +: IW] <= ((n + l) % 2 == 0) ? 7'h55 : 7'h2A;
          default: pix_data[l*IW +: IW] <= IW'(lfsr >> l) ^ IW'(l * 37);
        endcase
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      n++;
    end
  end

  // Reference model, write side: stream bits, bit 0 of a slice first (R1, R3).
  always @(posedge pix_clk) begin
    if (rst) begin
      for (int l = 0; l < LANES; l++) lane_q[l].delete();
    end else begin
      for (int l = 0; l < LANES; l++)
        for (int b = 0; b < IW; b++) lane_q[l].push_back(pix_data[l*IW + b]);
    end
  end

  // Reference model, read side: which word the last edge produced.
  always @(posedge ser_clk) begin
    if (rst) word_idx <= -1;
    else     word_idx <= word_idx + 1;
    last_rst <= rst;
  end

  // Compare away from the active edge (R2, R4, R5, R6, R7, R9).
  always @(negedge ser_clk) begin
    if (!done) begin
      if (last_rst) begin
        checks++;
        if (ser_data !== '0) begin
          errors++;
          $display("FAIL R5 ser_data in reset got %h exp 0", ser_data);
        end
      end else if (word_idx >= PRIME) begin
        for (int l = 0; l < LANES; l++) begin
          logic [OW-1:0] exp_w;
          checks++;
          if (lane_q[l].size() < OW) begin
            errors++;
            $display("FAIL R4 lane %0d word %0d got %h exp <no data>", l, word_idx,
                     ser_data[l*OW +: OW]);
          end else begin
            for (int b = 0; b < OW; b++) exp_w[b] = lane_q[l].pop_front();
            if (ser_data[l*OW +: OW] !== exp_w) begin
              errors++;
              $display("FAIL %s lane %0d word %0d got %h exp %h",
                       (word_idx == PRIME) ? "R6" : "R4", l, word_idx,
                       ser_data[l*OW +: OW], exp_w);
            end
          end
        end
      end
    end
  end

  task automatic apply_reset(input int cyc);
    @(negedge ser_clk); #1 rst = 1'b1;
    repeat (cyc) @(negedge ser_clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge ser_clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge ser_clk);           // R5 checks during reset
    #1 rst = 1'b0;
    mode = 0; repeat (400) @(negedge ser_clk);  // counter pattern, many wraps (R9)
    mode = 1; repeat (300) @(negedge ser_clk);  // alternating pattern
    apply_reset(5);                             // mid-stream restart (R7)
    mode = 2; repeat (400) @(negedge ser_clk);  // pseudo-random, per-lane (R8)
    apply_reset(3);
    mode = 0; repeat (120) @(negedge ser_clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule